// File: doc/BRIEF.md
# Line Access Switch Control Sequencer

This block is the digital control core of a solid-state replacement for a line card's ringing relay. It drives the enables of four switches: two break switches that connect the tip and ring conductors to the subscriber line interface circuit, one ringing-return switch and one ringing-injection switch. It decides which of them may close from a supply-valid flag, an active-low enable, two mode selects and a strobe from an external detector that marks zero crossings of the ringing current.

While the supply is not valid, and after it becomes valid until the enable is seen low, every switch is held open. A board can therefore be hot-plugged or powered up while its control logic is still unconfigured, and only later be released for service. An undriven enable counts as high. While the enable is low the mode selects pick talk, ringing or all-off. While it is high the switch state is frozen. A direct change from ringing to talk closes the break switches first and keeps the injection switch closed until the next zero crossing (make-before-break). Stepping through all-off gives break-before-make.

Top module: `line_switch_seq`

## Requirements
- R1: While `supply_ok` is low all four switch enables are 0 in that same cycle, whatever the other inputs are, and `state_o` reads all-off (code 0) after the next clock edge.
- R2: When `latch_oe` is 0 the enable counts as high whatever the value on `latch_n`, so the switch state does not change because of the mode inputs.
- R3: After the supply becomes valid the block stays all-off until the enable is seen low. At the first clock edge with `latch_oe`=1 and `latch_n`=0 it takes the state the mode inputs select.
- R4: If the enable is already low when `supply_ok` rises, the block goes from all-off to the selected state at the first clock edge with the supply valid.
- R5: While the enable is high the state is frozen and changes on `ring_sel` and `all_off_req` have no effect.
- R6: Encoding with the enable low: `all_off_req`=1 selects all-off (code 0, no switch closed). Otherwise `ring_sel`=1 selects ringing (code 2, return and injection closed) and `ring_sel`=0 selects talk (code 1, both break switches closed).
- R7: Selecting talk while in ringing enters make-before-break (code 3) at the next edge: both break switches closed, return open, injection still closed. The first edge in code 3 with `zc_strobe`=1 moves to talk. The enable being high does not block this release.
- R8: The sequence ringing, all-off, talk opens return and injection one cycle before the break switches close, and the return switch is never closed together with a break switch.
- R9: `all_off_req` with the enable low opens all four switches at the next edge from any state, including make-before-break.
- R10: Selecting ringing while in make-before-break re-enters ringing at the next edge.
- R11: While `rst_n` is low the state is all-off and no switch is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply-valid flag |
| latch_oe | input | 1 | Enable driver active; 0 models an undriven, pulled-up enable |
| latch_n | input | 1 | Active-low enable value when driven |
| ring_sel | input | 1 | 1 selects ringing, 0 selects talk |
| all_off_req | input | 1 | Thermal-shutdown / all-off request |
| zc_strobe | input | 1 | One-cycle ringing-current zero-crossing strobe |
| brk_tip_en | output | 1 | Tip break switch enable |
| brk_ring_en | output | 1 | Ring break switch enable |
| ring_ret_en | output | 1 | Ringing-return switch enable |
| ring_inj_en | output | 1 | Ringing-injection switch enable |
| state_o | output | 2 | 0 all-off, 1 talk, 2 ringing, 3 make-before-break pending |

## Verification
The assertions assume that every input is synchronous to `clk` and settled before each rising edge, and that `zc_strobe` is a single-cycle pulse. They do not assume any ordering between the enable and the mode selects. The bench changes all inputs on falling edges only. Its random phase draws the zero-crossing strobe as a sparse pulse and biases the enable toward low, so that transitions through make-before-break, its release and its interruption all occur often.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

  localparam int unsigned LSW_STATE_W = 2;
  localparam int unsigned LSW_NUM_SW  = 4;

  typedef enum logic [LSW_STATE_W-1:0] {
    LSW_OFF  = 2'd0,
    LSW_TALK = 2'd1,
    LSW_RING = 2'd2,
    LSW_MBB  = 2'd3
  } lsw_state_e;

  // bit 0 tip break, bit 1 ring break, bit 2 ringing return, bit 3 injection
  typedef logic [LSW_NUM_SW-1:0] lsw_sw_t;

  function automatic lsw_sw_t lsw_pattern(lsw_state_e s);
    lsw_sw_t p;
    case (s)
      LSW_TALK: p = 4'b0011;
      LSW_RING: p = 4'b1100;
      LSW_MBB:  p = 4'b1011;
      default:  p = 4'b0000;
    endcase
    return p;
  endfunction

  function automatic lsw_state_e lsw_target(logic all_off, logic ring);
    if (all_off) return LSW_OFF;
    if (ring)    return LSW_RING;
    return LSW_TALK;
  endfunction

endpackage

// File: rtl/lsw_enable_gate.sv
module lsw_enable_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic latch_oe,
  input  logic latch_n,
  output logic latch_open
);
  logic latch_eff_n;

  // an undriven enable is pulled high
  assign latch_eff_n = latch_oe ? latch_n : 1'b1;
  assign latch_open  = supply_ok & ~latch_eff_n;

  p_undriven_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_oe |-> !latch_open);
endmodule

// File: rtl/lsw_mode_fsm.sv
module lsw_mode_fsm
  import lsw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       latch_open,
  input  logic       ring_sel,
  input  logic       all_off_req,
  input  logic       zc_strobe,
  output lsw_state_e state_q
);
  lsw_state_e nxt;
  lsw_state_e tgt;
  logic       ev_release;

  assign tgt        = lsw_target(all_off_req, ring_sel);
  assign ev_release = (state_q == LSW_MBB) && zc_strobe;

  always_comb begin
    nxt = state_q;
    if (!supply_ok) begin
      nxt = LSW_OFF;
    end else if (latch_open) begin
      if (tgt == LSW_TALK && state_q == LSW_RING)
        nxt = LSW_MBB;
      else if (tgt == LSW_TALK && state_q == LSW_MBB)
        nxt = ev_release ? LSW_TALK : LSW_MBB;
      else
        nxt = tgt;
    end else if (ev_release) begin
      nxt = LSW_TALK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LSW_OFF;
    else        state_q <= nxt;
  end

  p_supply_low_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> state_q == LSW_OFF);
  p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && !latch_open && state_q != LSW_MBB) |=> $stable(state_q));
  p_mbb_enter_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && latch_open && state_q == LSW_RING && !all_off_req && !ring_sel)
      |=> state_q == LSW_MBB);
  p_mbb_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && state_q == LSW_MBB && zc_strobe &&
     !(latch_open && (all_off_req || ring_sel))) |=> state_q == LSW_TALK);
  p_all_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && latch_open && all_off_req) |=> state_q == LSW_OFF);
  p_back_to_ring_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && latch_open && state_q == LSW_MBB && !all_off_req && ring_sel)
      |=> state_q == LSW_RING);
endmodule

// File: rtl/lsw_switch_decode.sv
module lsw_switch_decode
  import lsw_pkg::*;
#(
  parameter int unsigned NUM_SW = LSW_NUM_SW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  lsw_state_e        state_q,
  output logic [NUM_SW-1:0] sw_en
);
  lsw_sw_t pat;
  assign pat = lsw_pattern(state_q);

  for (genvar i = 0; i < NUM_SW; i++) begin : g_sw
    assign sw_en[i] = supply_ok & pat[i];
  end

  p_supply_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> sw_en == '0);
  p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_en[2] && (sw_en[0] || sw_en[1])));
endmodule

// File: rtl/line_switch_seq.sv
module line_switch_seq
  import lsw_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   supply_ok,
  input  logic                   latch_oe,
  input  logic                   latch_n,
  input  logic                   ring_sel,
  input  logic                   all_off_req,
  input  logic                   zc_strobe,
  output logic                   brk_tip_en,
  output logic                   brk_ring_en,
  output logic                   ring_ret_en,
  output logic                   ring_inj_en,
  output logic [LSW_STATE_W-1:0] state_o
);
  logic       latch_open;
  lsw_state_e state_q;
  lsw_sw_t    sw_en;

  lsw_enable_gate u_gate (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
    .latch_oe(latch_oe), .latch_n(latch_n), .latch_open(latch_open)
  );

  lsw_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .latch_open(latch_open),
    .ring_sel(ring_sel), .all_off_req(all_off_req), .zc_strobe(zc_strobe),
    .state_q(state_q)
  );

  lsw_switch_decode #(.NUM_SW(LSW_NUM_SW)) u_dec (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .state_q(state_q),
    .sw_en(sw_en)
  );

  assign brk_tip_en  = sw_en[0];
  assign brk_ring_en = sw_en[1];
  assign ring_ret_en = sw_en[2];
  assign ring_inj_en = sw_en[3];
  assign state_o     = state_q;

  p_reset_off_r11: assert property (@(posedge clk)
    !rst_n |-> (state_o == 2'd0 && sw_en == '0));
endmodule

// File: tb/tb_line_switch_seq.sv
`timescale 1ns/1ps
module tb_line_switch_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0, latch_oe = 1'b0, latch_n = 1'b1;
  logic ring_sel = 1'b0, all_off_req = 1'b0, zc_strobe = 1'b0;
  logic brk_tip_en, brk_ring_en, ring_ret_en, ring_inj_en;
  logic [1:0] state_o;

  int n_checks = 0;
  int n_fails  = 0;
  logic [1:0] exp_st = 2'd0;

  always #4 clk = ~clk;

  line_switch_seq dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .latch_oe(latch_oe),
    .latch_n(latch_n), .ring_sel(ring_sel), .all_off_req(all_off_req),
    .zc_strobe(zc_strobe), .brk_tip_en(brk_tip_en), .brk_ring_en(brk_ring_en),
    .ring_ret_en(ring_ret_en), .ring_inj_en(ring_inj_en), .state_o(state_o)
  );

  // bench view of the rules: 0 off, 1 talk, 2 ring, 3 make-before-break
  function automatic logic [1:0] model_next(logic [1:0] cur, logic s, logic oe,
      logic ln, logic rg, logic off, logic zc);
    logic enabled;
    enabled = oe && !ln;
    if (!s) return 2'd0;
    if (!enabled) return (cur == 2'd3 && zc) ? 2'd1 : cur;
    if (off) return 2'd0;
    if (rg) return 2'd2;
    case (cur)
      2'd2:    return 2'd3;
      2'd3:    return zc ? 2'd1 : 2'd3;
      default: return 2'd1;
    endcase
  endfunction

  // {inj, ret, ring break, tip break}
  function automatic logic [3:0] model_sw(logic [1:0] st, logic s);
    if (!s) return 4'b0000;
    case (st)
      2'd1:    return 4'b0011;
      2'd2:    return 4'b1100;
      2'd3:    return 4'b1011;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [3:0] act_sw();
    return {ring_inj_en, ring_ret_en, brk_ring_en, brk_tip_en};
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic s, input logic oe, input logic ln, input logic rg,
                      input logic off, input logic zc, input string tag);
    @(negedge clk);
    supply_ok = s; latch_oe = oe; latch_n = ln;
    ring_sel = rg; all_off_req = off; zc_strobe = zc;
    #1;
    if (!s) check({tag, " R1 same-cycle"}, act_sw(), 4'b0000);
    @(posedge clk);
    exp_st = model_next(exp_st, s, oe, ln, rg, off, zc);
    #2;
    check({tag, " state"}, {2'b00, state_o}, {2'b00, exp_st});
    check({tag, " switches"}, act_sw(), model_sw(exp_st, s));
  endtask

  initial begin
    #(8 * 150000);
    n_fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    supply_ok = 1'b1; latch_oe = 1'b1; latch_n = 1'b0; ring_sel = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset state", {2'b00, state_o}, 4'b0000);
    check("R11 reset switches", act_sw(), 4'b0000);
    @(negedge clk);
    supply_ok = 1'b0; rst_n = 1'b1;
    exp_st = 2'd0;

    // R1: supply low blocks everything
    step(0, 1, 0, 1, 0, 0, "R1 supply low ring");
    step(0, 1, 0, 0, 0, 1, "R1 supply low talk");
    // R2: undriven enable holds all-off
    step(1, 0, 0, 1, 0, 0, "R2 undriven");
    step(1, 0, 0, 0, 0, 0, "R2 undriven talk");
    // R3: driven high then low
    step(1, 1, 1, 1, 0, 0, "R3 enable high");
    step(1, 1, 0, 1, 0, 0, "R3 R6 enable low ring");
    // R5: frozen while enable high
    step(1, 1, 1, 0, 0, 0, "R5 frozen talk req");
    step(1, 1, 1, 0, 1, 0, "R5 frozen off req");
    // R7: make-before-break with release on zero crossing
    step(1, 1, 0, 0, 0, 0, "R7 enter mbb");
    step(1, 1, 0, 0, 0, 0, "R7 hold mbb");
    step(1, 1, 0, 0, 0, 1, "R7 release");
    step(1, 1, 0, 0, 0, 0, "R6 talk");
    // R10: back to ringing from pending
    step(1, 1, 0, 1, 0, 0, "R10 ring");
    step(1, 1, 0, 0, 0, 0, "R10 mbb");
    step(1, 1, 0, 1, 0, 0, "R10 back to ring");
    // R9: all-off overrides pending
    step(1, 1, 0, 0, 0, 0, "R9 mbb");
    step(1, 1, 0, 0, 1, 1, "R9 all-off over mbb");
    // R8: break-before-make
    step(1, 1, 0, 1, 0, 0, "R8 ring");
    step(1, 1, 0, 1, 1, 0, "R8 off");
    step(1, 1, 0, 0, 0, 0, "R8 talk");
    // R7: release while enable high
    step(1, 1, 0, 1, 0, 0, "R7 ring");
    step(1, 1, 0, 0, 0, 0, "R7 mbb");
    step(1, 1, 1, 1, 0, 1, "R7 release latched");
    // R4: enable already low at supply rise
    step(0, 1, 0, 0, 0, 0, "R4 supply low");
    step(1, 1, 0, 0, 0, 0, "R4 supply rise talk");

    for (int i = 0; i < 3000; i++) begin
      logic s, oe, ln, rg, off, zc;
      s   = ($urandom % 16) != 0;
      oe  = ($urandom % 8) != 0;
      ln  = ($urandom % 4) == 0;
      rg  = $urandom % 2;
      off = ($urandom % 8) == 0;
      zc  = ($urandom % 5) == 0;
      step(s, oe, ln, rg, off, zc, "R6 R7 R9 R10 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule